// File: doc/BRIEF.md
# Sleep and Wakeup Power Controller

This block sequences a small microcontroller into and out of a low-power state. Software writes a sleep mode word that chooses the sleep depth (hibernate or doze), how many RAM pages keep power, whether core logic state is retained and whether the digital pads stay powered. It also programs a wake timer with an enable bit and a timeout in slow sleep-clock ticks. The slow clock is modelled by a one-cycle `sleep_tick` pulse in the main clock domain.

Both transitions are paced by one status flag that software clears by writing 1. A valid mode write raises the flag and leaves the chip fully powered. Clearing the flag commits the power-down: the sleep configuration is applied to the outputs and the wake counter is loaded. When the counter runs out with wake enabled, the flag rises again with the sleep configuration still applied. Clearing the flag a second time restores full power.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, all RAM page enables and pad power are 1, core state retention, sleep_active, hibernate_on and doze_on are 0, and every register reads 0.
- R2: Register addresses are 0 for the mode word, 1 for wake control, 2 for the timeout and 3 for status. While awake, a mode write with bit 0 or bit 1 set raises status bit 0 and leaves sleep_active at 0. A mode write with bits 1:0 both clear raises no flag.
- R3: During sleep, mode bit 0 selects hibernate (hibernate_on=1). Mode bit 1 alone selects doze (doze_on=1). Both bits set selects hibernate. Exactly one of the two outputs is high while sleep_active is 1, and it holds steady for the whole interval.
- R4: Writing 1 to status bit 0 while the entry flag is set clears the flag and raises sleep_active on the next clock edge. Writing 0 to the status bit has no effect. Writing 1 while the flag is clear has no effect.
- R5: During sleep, ram_pwr_en[p] is 1 exactly when p is at most mode bits 5:4, so page 0 always keeps power. Outside sleep every page enable is 1.
- R6: During sleep, core_state_ret equals mode bit 6 and pad_pwr_en equals mode bit 7. Outside sleep core_state_ret is 0 and pad_pwr_en is 1.
- R7: With wake control bit 0 set, status bit 0 rises on the sleep tick numbered max(T,1) after entry, where T is the timeout loaded at entry. All sleep outputs hold until the flag is cleared.
- R8: With wake control bit 0 clear, no number of sleep ticks raises the flag.
- R9: Writing 1 to the status bit while the wake flag is set clears the flag and restores the awake outputs. A new sleep request is then accepted.
- R10: Reads return the mode word in bits 7:0, the wake enable in bit 0, the full timeout, and the flag in bit 0. A mode write made while not awake leaves the mode word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for writes and reads |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| sleep_tick | input | 1 | One-cycle pulse per slow sleep-clock period |
| ram_pwr_en | output | NUM_PAGES | Power enable per RAM page |
| core_state_ret | output | 1 | Retain core logic state |
| pad_pwr_en | output | 1 | Digital pad power enable |
| sleep_active | output | 1 | Sleep configuration applied |
| hibernate_on | output | 1 | Sleeping in hibernate depth |
| doze_on | output | 1 | Sleeping in doze depth |

## Verification
The full sequence runs with random mode words that cover every retention range and all combinations of the state and pad bits. This separates the page mask from the other retention controls. Random timeouts from 0 to 5 check the off-by-one boundary between a count of 0 and a count of 1. Mixing enabled and disabled wake timers checks that an expired count alone does nothing until the enable is set. Directed cases cover the two-bit depth conflict, a word with no depth bit, writes of 0 and stray writes of 1 to the status bit, and mode writes during sleep. Together they show that the handshake, rather than time or the bus alone, moves the sequence.

// File: rtl/pwr_sleep_pkg.sv
// Shared types for the sleep/wakeup power controller.
// Assumes a 2-bit register address space and at most four RAM pages.
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        PS_AWAKE      = 2'd0,
        PS_ENTRY_SYNC = 2'd1,
        PS_ASLEEP     = 2'd2,
        PS_WAKE_SYNC  = 2'd3
    } pwr_state_e;

    localparam logic [1:0] RA_MODE     = 2'd0;
    localparam logic [1:0] RA_WAKE_CTL = 2'd1;
    localparam logic [1:0] RA_TIMEOUT  = 2'd2;
    localparam logic [1:0] RA_STATUS   = 2'd3;

    // Mode word field positions; the bench and software rely on them.
    localparam int MB_HIB   = 0;
    localparam int MB_DOZE  = 1;
    localparam int MB_RAM   = 4;
    localparam int MB_STATE = 6;
    localparam int MB_PAD   = 7;

    typedef struct packed {
        logic       pad_keep;
        logic       state_keep;
        logic [1:0] ram_sel;
        logic       hib;
    } sleep_cfg_t;

endpackage

// File: rtl/pwr_sleep_regs.sv
// Register file and bus decode.
// Holds the mode word, the wake enable and the timeout, and decodes
// sleep requests and status acknowledges. A mode write is accepted only
// while mode_wr_allow is high. Reads are combinational from bus_addr.
module pwr_sleep_regs
    import pwr_sleep_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TMR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              mode_wr_allow,
    input  logic              sync_flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wake_en,
    output logic [TMR_W-1:0]  timeout,
    output logic              mode_req,
    output sleep_cfg_t        req_cfg,
    output logic              status_ack
);

    logic [7:0] mode_word;
    logic       wr_mode;

    assign wr_mode = bus_wr && (bus_addr == RA_MODE) && mode_wr_allow;

    // A request needs at least one depth bit in the written word.
    assign mode_req   = wr_mode && (bus_wdata[MB_HIB] || bus_wdata[MB_DOZE]);
    // Only a written 1 acknowledges; a written 0 is dropped here.
    assign status_ack = bus_wr && (bus_addr == RA_STATUS) && bus_wdata[0];

    // Decode the requested configuration straight from the write data.
    always_comb begin
        req_cfg.hib        = bus_wdata[MB_HIB];
        req_cfg.ram_sel    = bus_wdata[MB_RAM +: 2];
        req_cfg.state_keep = bus_wdata[MB_STATE];
        req_cfg.pad_keep   = bus_wdata[MB_PAD];
    end

    // Store the mode word on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_word <= '0;
        end else if (wr_mode) begin
            mode_word <= bus_wdata[7:0];
        end
    end

    // Store the wake enable and the timeout on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en <= 1'b0;
            timeout <= '0;
        end else if (bus_wr) begin
            if (bus_addr == RA_WAKE_CTL) wake_en <= bus_wdata[0];
            if (bus_addr == RA_TIMEOUT)  timeout <= bus_wdata[TMR_W-1:0];
        end
    end

    // Return the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_MODE:     bus_rdata[7:0] = mode_word;
            RA_WAKE_CTL: bus_rdata[0]   = wake_en;
            RA_TIMEOUT:  bus_rdata      = DATA_W'(timeout);
            default:     bus_rdata[0]   = sync_flag;
        endcase
    end

endmodule

// File: rtl/pwr_sleep_timer.sv
// Wake countdown timer.
// Loads the timeout at power-down and decrements once per sleep tick
// while running. It expires on a tick that takes the count to zero, or
// that finds it already zero, with the enable set.
module pwr_sleep_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    input  logic             en,
    output logic             expire
);

    logic [TMR_W-1:0] cnt;

    // Expiry: a counted tick with the count at one or at zero.
    assign expire = run && tick && en && (cnt <= TMR_W'(1));

    // Load at entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick && (cnt != '0)) begin
            cnt <= cnt - TMR_W'(1);
        end
    end

endmodule

// File: rtl/pwr_sleep_fsm.sv
// Power sequencing state machine.
// The four states are awake, entry-sync, asleep and wake-sync. The sync
// flag is high exactly in the two sync states. It latches the sleep
// configuration when a request is accepted.
module pwr_sleep_fsm
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req,
    input  sleep_cfg_t req_cfg,
    input  logic       status_ack,
    input  logic       timer_expire,
    output pwr_state_e state,
    output sleep_cfg_t cfg,
    output logic       sync_flag,
    output logic       timer_load,
    output logic       timer_run
);

    pwr_state_e state_nx;

    assign sync_flag  = (state == PS_ENTRY_SYNC) || (state == PS_WAKE_SYNC);
    assign timer_load = (state == PS_ENTRY_SYNC) && status_ack;
    assign timer_run  = (state == PS_ASLEEP);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            PS_AWAKE:      if (mode_req)     state_nx = PS_ENTRY_SYNC;
            PS_ENTRY_SYNC: if (status_ack)   state_nx = PS_ASLEEP;
            PS_ASLEEP:     if (timer_expire) state_nx = PS_WAKE_SYNC;
            default:       if (status_ack)   state_nx = PS_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_AWAKE;
        else        state <= state_nx;
    end

    // Latch the requested configuration when leaving the awake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if ((state == PS_AWAKE) && mode_req) begin
            cfg <= req_cfg;
        end
    end

endmodule

// File: rtl/pwr_sleep_outputs.sv
// Power domain output decode.
// Outputs are combinational from the sleeping state and the latched
// configuration. Page p keeps power when p is at most ram_sel.
// Assumes NUM_PAGES is at most 4.
module pwr_sleep_outputs
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                 sleeping,
    input  sleep_cfg_t           cfg,
    output logic [NUM_PAGES-1:0] ram_pwr_en,
    output logic                 core_state_ret,
    output logic                 pad_pwr_en,
    output logic                 hibernate_on,
    output logic                 doze_on
);

    // One enable per page.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        localparam logic [1:0] P_IDX = 2'(p);
        assign ram_pwr_en[p] = !sleeping || (P_IDX <= cfg.ram_sel);
    end

    // Domain-level controls.
    always_comb begin
        core_state_ret = sleeping && cfg.state_keep;
        pad_pwr_en     = !sleeping || cfg.pad_keep;
        hibernate_on   = sleeping && cfg.hib;
        doze_on        = sleeping && !cfg.hib;
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Sleep and wakeup power controller, top level.
// Connects the register file, the sequencer, the wake timer and the
// output decode. sleep_tick must be a single-cycle pulse in clk domain.
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TMR_W     = 32,
    parameter int NUM_PAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 sleep_tick,
    output logic [NUM_PAGES-1:0] ram_pwr_en,
    output logic                 core_state_ret,
    output logic                 pad_pwr_en,
    output logic                 sleep_active,
    output logic                 hibernate_on,
    output logic                 doze_on
);

    pwr_state_e       state;
    sleep_cfg_t       cfg;
    sleep_cfg_t       req_cfg;
    logic             sync_flag;
    logic             wake_en;
    logic [TMR_W-1:0] timeout;
    logic             mode_req;
    logic             status_ack;
    logic             timer_load;
    logic             timer_run;
    logic             timer_expire;

    // The sleep configuration applies from commit until wake acknowledge.
    assign sleep_active = (state == PS_ASLEEP) || (state == PS_WAKE_SYNC);

    pwr_sleep_regs #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mode_wr_allow(state == PS_AWAKE),
        .sync_flag(sync_flag), .bus_rdata(bus_rdata), .wake_en(wake_en),
        .timeout(timeout), .mode_req(mode_req), .req_cfg(req_cfg),
        .status_ack(status_ack)
    );

    pwr_sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .req_cfg(req_cfg),
        .status_ack(status_ack), .timer_expire(timer_expire),
        .state(state), .cfg(cfg), .sync_flag(sync_flag),
        .timer_load(timer_load), .timer_run(timer_run)
    );

    pwr_sleep_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timeout),
        .run(timer_run), .tick(sleep_tick), .en(wake_en),
        .expire(timer_expire)
    );

    pwr_sleep_outputs #(.NUM_PAGES(NUM_PAGES)) u_out (
        .sleeping(sleep_active), .cfg(cfg), .ram_pwr_en(ram_pwr_en),
        .core_state_ret(core_state_ret), .pad_pwr_en(pad_pwr_en),
        .hibernate_on(hibernate_on), .doze_on(doze_on)
    );

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
// Assertion checker for pwr_sleep_ctrl, attached by bind.
// It sees the ports plus the sync flag and the wake enable.
module pwr_sleep_ctrl_chk #(
    parameter int NUM_PAGES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stat_one_wr,
    input logic [NUM_PAGES-1:0] ram_pwr_en,
    input logic                 core_state_ret,
    input logic                 pad_pwr_en,
    input logic                 sleep_active,
    input logic                 hibernate_on,
    input logic                 doze_on,
    input logic                 sync_flag,
    input logic                 wake_en
);

    AST_PAGE0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_pwr_en[0]); // R5

    AST_AWAKE_FULL_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_active |-> ((&ram_pwr_en) && pad_pwr_en && !core_state_ret)); // R6

    AST_ONE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> (hibernate_on ^ doze_on)); // R3

    AST_DEPTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && $past(sleep_active)) |-> ($stable(hibernate_on) && $stable(ram_pwr_en))); // R3

    AST_ENTRY_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> $past(stat_one_wr)); // R4

    AST_EXIT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_active) |-> $past(stat_one_wr)); // R9

    AST_NO_TIMER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && !sync_flag && !wake_en) |=> !sync_flag); // R8

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .stat_one_wr(bus_wr && (bus_addr == 2'd3) && bus_wdata[0]),
    .ram_pwr_en(ram_pwr_en), .core_state_ret(core_state_ret),
    .pad_pwr_en(pad_pwr_en), .sleep_active(sleep_active),
    .hibernate_on(hibernate_on), .doze_on(doze_on),
    .sync_flag(sync_flag), .wake_en(wake_en)
);

// File: tb/pwr_sleep_ctrl_bench.sv
module pwr_sleep_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sleep_tick = 1'b0;
    logic [NP-1:0] ram_pwr_en;
    logic          core_state_ret, pad_pwr_en, sleep_active, hibernate_on, doze_on;

    int n_tests = 0;
    int n_fail  = 0;

    pwr_sleep_ctrl u_pwr_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_tick(sleep_tick),
        .ram_pwr_en(ram_pwr_en), .core_state_ret(core_state_ret),
        .pad_pwr_en(pad_pwr_en), .sleep_active(sleep_active),
        .hibernate_on(hibernate_on), .doze_on(doze_on)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [NP-1:0] exp_ram(input logic [1:0] sel);
        logic [NP-1:0] m;
        for (int p = 0; p < NP; p++) m[p] = (p <= int'(sel));
        return m;
    endfunction

    function automatic int exp_wake_tick(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sleep_tick = 1'b1;
        @(negedge clk);
        sleep_tick = 1'b0;
    endtask

    task automatic check_awake(input string req);
        check(req, 32'(ram_pwr_en), 32'(exp_ram(2'd3)));
        check(req, {core_state_ret, pad_pwr_en, sleep_active, hibernate_on, doze_on}, 32'b01000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_awake("R1");
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1", r, 0);
        end

        // R4 stray acknowledge while idle does nothing
        wr(2'd3, 32'd1);
        check("R4", {31'd0, sleep_active}, 0);
        rd(2'd3, r);
        check("R4", r, 0);

        for (int it = 0; it < 24; it++) begin
            logic [7:0] w;
            int         t;
            logic       en;
            t  = int'($urandom % 6);
            en = ($urandom % 4) != 0;
            w  = 8'($urandom) & 8'hF3;
            if (it == 0) w = 8'h03;
            if (it == 1) w = 8'h00;
            if (it == 2) w = 8'hF1;
            if (it == 3) begin w = 8'h32; t = 0; en = 1'b1; end
            if (it == 4) begin w = 8'h02; t = 1; en = 1'b1; end
            if (it == 5) begin w = 8'h41; en = 1'b0; end

            wr(2'd2, 32'(t));
            wr(2'd1, {31'd0, en});
            wr(2'd0, {24'd0, w});
            rd(2'd0, r);
            check("R10", r, {24'd0, w});
            rd(2'd2, r);
            check("R10", r, 32'(t));
            rd(2'd1, r);
            check("R10", r, {31'd0, en});
            rd(2'd3, r);
            if (w[1:0] == 2'b00) begin
                check("R2", r, 0);
                check("R2", {31'd0, sleep_active}, 0);
                continue;
            end
            check("R2", r, 1);
            check("R2", {31'd0, sleep_active}, 0);

            // R4 writing 0 to status has no effect
            wr(2'd3, 32'd0);
            rd(2'd3, r);
            check("R4", r, 1);
            check("R4", {31'd0, sleep_active}, 0);

            // R4 commit
            wr(2'd3, 32'd1);
            check("R4", {31'd0, sleep_active}, 1);
            rd(2'd3, r);
            check("R4", r, 0);
            check("R5", 32'(ram_pwr_en), 32'(exp_ram(w[5:4])));
            check("R6", {31'd0, core_state_ret}, {31'd0, w[6]});
            check("R6", {31'd0, pad_pwr_en}, {31'd0, w[7]});
            check("R3", {30'd0, hibernate_on, doze_on}, {30'd0, w[0], !w[0]});

            // R10 mode write while asleep is ignored
            wr(2'd0, {24'd0, ~w});
            rd(2'd0, r);
            check("R10", r, {24'd0, w});

            if (en) begin
                for (int i = 1; i <= exp_wake_tick(t); i++) begin
                    tick();
                    rd(2'd3, r);
                    check("R7", r, (i == exp_wake_tick(t)) ? 1 : 0);
                end
            end else begin
                for (int i = 0; i < t + 3; i++) tick();
                rd(2'd3, r);
                check("R8", r, 0);
                check("R8", {31'd0, sleep_active}, 1);
                wr(2'd1, 32'd1);
                tick();
                rd(2'd3, r);
                check("R7", r, 1);
            end
            // R7 sleep outputs held while the wake flag waits
            check("R7", {31'd0, sleep_active}, 1);
            check("R7", 32'(ram_pwr_en), 32'(exp_ram(w[5:4])));

            wr(2'd3, 32'd1);
            rd(2'd3, r);
            check("R9", r, 0);
            check_awake("R9");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule